// File: doc/BRIEF.md
# Dual-Lane ADC Ramp Pattern Checker

This block monitors a packed word carrying two converter lanes, I and Q, while the converter emits an incrementing ramp test pattern. Each lane is followed by its own checker. A checker waits for a zero sample to find the ramp phase. From then on it compares every qualified sample against the one that came before it. The block reports lock and errors separately for each lane. Software can therefore tell a lane that never found the ramp from a lane that found it and later saw corrupted samples.

Each lane is 16 bits wide. The 14-bit sample sits in the upper bits of the lane, and the two lowest bits are padding. The I lane travels inverted in the packed word, so the block inverts it back before checking. The checker is armed by raising the enable. Lowering the enable wipes all state, and raising it again starts a fresh acquisition.

Top module: `ramp_chk_pair`

## Requirements
- R1: After reset, both locked flags, both error flags and both error counts are 0.
- R2: While enabled, a lane stays unlocked until a valid sample equal to zero arrives. Its locked output is 1 on the cycle after that sample is clocked in.
- R3: Once locked, each valid sample must equal the previous valid sample plus one, modulo 2^14, so 0x3FFF followed by 0 is correct. Any other value sets that lane's error flag on the next cycle, and that sample becomes the new reference.
- R4: An error flag stays set while enable stays high, even if correct samples follow.
- R5: Enable low for one cycle clears locked, error and count of both lanes on the next cycle. This clear takes priority over a mismatch presented in the same cycle. After re-enabling, a fresh zero sample is needed to lock.
- R6: Lane bits [1:0] have no effect on lock or checking. The sample is lane bits [15:2].
- R7: The I lane is word bits [31:16] and is bit-inverted in the word. The Q lane is word bits [15:0] and is not inverted.
- R8: A cycle with valid low neither acquires, nor advances, nor checks the ramp.
- R9: Each lane has a 16-bit error count that increments once per mismatching sample and saturates at 0xFFFF.
- R10: The lanes are independent: a mismatch on one lane does not affect the other lane's flags or count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Arm; low clears both lanes |
| valid | input | 1 | Qualifies the word this cycle |
| word | input | 32 | Packed word: inverted I in [31:16], Q in [15:0] |
| i_locked | output | 1 | I lane has acquired the ramp |
| i_err | output | 1 | Sticky I lane mismatch flag |
| i_err_cnt | output | 16 | Saturating I lane mismatch count |
| q_locked | output | 1 | Q lane has acquired the ramp |
| q_err | output | 1 | Sticky Q lane mismatch flag |
| q_err_cnt | output | 16 | Saturating Q lane mismatch count |

## Verification
Two events can fall in the same cycle: the clear caused by enable going low, and the detection of a mismatching sample. The bench provokes this by dropping enable on the exact cycle that a broken Q sample is presented with valid high. It then expects every flag and count to read zero on the following cycle. The bench also presents a zero sample during that disabled cycle. Because the lane must stay unlocked after re-arming, this shows that neither acquisition nor checking leaked through the clear.

// File: rtl/ramp_chk_pair.sv
module ramp_chk_pair #(
  parameter int SAMPLE_W = 14,
  parameter int PAD_W    = 2,
  parameter int CNT_W    = 16
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              en,
  input  logic                              valid,
  input  logic [2*(SAMPLE_W+PAD_W)-1:0]     word,
  output logic                              i_locked,
  output logic                              i_err,
  output logic [CNT_W-1:0]                  i_err_cnt,
  output logic                              q_locked,
  output logic                              q_err,
  output logic [CNT_W-1:0]                  q_err_cnt
);
  localparam int LANE_W = SAMPLE_W + PAD_W;

  logic             lock_q [2];
  logic             err_q  [2];
  logic [CNT_W-1:0] cnt_q  [2];

  for (genvar g = 0; g < 2; g++) begin : g_lane
    logic [LANE_W-1:0]   lane;
    logic [SAMPLE_W-1:0] smp, prev_q, expect_v;

    if (g == 0) begin : g_inv
      assign lane = ~word[2*LANE_W-1:LANE_W];
    end else begin : g_dir
      assign lane = word[LANE_W-1:0];
    end

    assign smp      = lane[LANE_W-1 -: SAMPLE_W];
    assign expect_v = prev_q + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lock_q[g] <= 1'b0;
        err_q[g]  <= 1'b0;
        cnt_q[g]  <= '0;
        prev_q    <= '0;
      end else if (!en) begin
        lock_q[g] <= 1'b0;
        err_q[g]  <= 1'b0;
        cnt_q[g]  <= '0;
        prev_q    <= '0;
      end else if (valid) begin
        if (!lock_q[g]) begin
          if (smp == '0) begin
            lock_q[g] <= 1'b1;
            prev_q    <= smp;
          end
        end else begin
          if (smp != expect_v) begin
            err_q[g] <= 1'b1;
            if (cnt_q[g] != '1) cnt_q[g] <= cnt_q[g] + 1'b1;
          end
          prev_q <= smp;
        end
      end
    end
  end

  assign i_locked  = lock_q[0];
  assign i_err     = err_q[0];
  assign i_err_cnt = cnt_q[0];
  assign q_locked  = lock_q[1];
  assign q_err     = err_q[1];
  assign q_err_cnt = cnt_q[1];
endmodule

// File: rtl/ramp_chk_pair_chk.sv
module ramp_chk_pair_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             valid,
  input logic             i_locked,
  input logic             i_err,
  input logic [CNT_W-1:0] i_err_cnt,
  input logic             q_locked,
  input logic             q_err,
  input logic [CNT_W-1:0] q_err_cnt
);
  // R5
  clear_on_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!i_locked && !i_err && i_err_cnt == '0 && !q_locked && !q_err && q_err_cnt == '0));

  // R4
  i_err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en && i_err |=> i_err);

  // R4
  q_err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en && q_err |=> q_err);

  // R2
  i_lock_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(i_locked) |-> $past(valid && en));

  // R2
  q_lock_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(q_locked) |-> $past(valid && en));

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en && !valid |=> ($stable(i_locked) && $stable(i_err_cnt) && $stable(q_locked) && $stable(q_err_cnt)));

  // R9
  cnt_implies_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (i_err_cnt != '0 |-> i_err) and (q_err_cnt != '0 |-> q_err));

  // R9
  cnt_no_decrease_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> (i_err_cnt >= $past(i_err_cnt) && q_err_cnt >= $past(q_err_cnt)));
endmodule

bind ramp_chk_pair ramp_chk_pair_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .valid(valid),
  .i_locked(i_locked), .i_err(i_err), .i_err_cnt(i_err_cnt),
  .q_locked(q_locked), .q_err(q_err), .q_err_cnt(q_err_cnt)
);

// File: tb/tb_ramp_chk_pair.sv
module tb_ramp_chk_pair;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic        valid = 1'b0;
  logic [31:0] word = '0;
  logic        i_locked, i_err, q_locked, q_err;
  logic [15:0] i_err_cnt, q_err_cnt;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  ramp_chk_pair dut (
    .clk(clk), .rst_n(rst_n), .en(en), .valid(valid), .word(word),
    .i_locked(i_locked), .i_err(i_err), .i_err_cnt(i_err_cnt),
    .q_locked(q_locked), .q_err(q_err), .q_err_cnt(q_err_cnt)
  );

  function automatic logic [31:0] mk(input logic [13:0] iv, input logic [13:0] qv,
                                     input logic [1:0] lo);
    return {~{iv, lo}, {qv, lo}};
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic e, input logic v, input logic [31:0] w);
    @(negedge clk);
    en = e; valid = v; word = w;
    @(posedge clk);
    #1;
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual=hung expected=done");
      summary();
    end
  end

  initial begin
    #35;
    check("R1 i_locked", i_locked, 0);
    check("R1 q_err_cnt", q_err_cnt, 0);
    check("R1 i_err", i_err, 0);
    rst_n = 1'b1;

    // R2: nonzero samples do not lock; R8: zero with valid low does not lock
    step(1, 1, mk(5, 5, 0));
    step(1, 1, mk(6, 6, 0));
    step(1, 0, mk(0, 0, 0));
    check("R2 unlocked before zero", {i_locked, q_locked}, 0);
    check("R8 no lock without valid", {i_locked, q_locked}, 0);
    // R6: zero sample with padding bits set still locks
    step(1, 1, mk(0, 0, 2'b11));
    check("R2 R6 locked after zero", {i_locked, q_locked}, 2'b11);

    // R3 R6 R7: full ramp through wrap, varying padding bits
    for (int k = 1; k <= 16384 + 5; k++)
      step(1, 1, mk(14'(k), 14'(k), 2'(k)));
    check("R3 R7 no error across wrap", {i_err, q_err}, 0);
    check("R3 count zero", i_err_cnt + q_err_cnt, 0);

    // R8: garbage with valid low neither checks nor advances (last sample 5)
    for (int k = 0; k < 4; k++) step(1, 0, mk(14'h1234, 14'h0abc, 0));
    step(1, 1, mk(6, 6, 0));
    check("R8 idle cycles ignored", {i_err, q_err, i_locked, q_locked}, 4'b0011);

    // R10 R3: I mismatch only
    step(1, 1, mk(10, 7, 0));
    check("R3 i_err set", i_err, 1);
    check("R9 i count one", i_err_cnt, 1);
    check("R10 q unaffected", {q_err, q_err_cnt}, 0);
    // R4: correct samples after the new reference keep flag set
    step(1, 1, mk(11, 8, 0));
    step(1, 1, mk(12, 9, 0));
    check("R4 i_err sticky", i_err, 1);
    check("R3 new reference no extra count", i_err_cnt, 1);

    // R5: disable in the same cycle as a Q mismatch and a zero sample
    step(0, 1, mk(0, 0, 0));
    check("R5 cleared", {i_locked, i_err, i_err_cnt, q_locked, q_err, q_err_cnt}, 0);
    step(1, 1, mk(3, 3, 0));
    check("R5 needs fresh zero", {i_locked, q_locked}, 0);
    step(1, 1, mk(0, 0, 0));
    check("R5 relock", {i_locked, q_locked}, 2'b11);

    // R9: Q stuck at 0 mismatches every sample; I keeps ramping
    for (int k = 1; k <= 100; k++) step(1, 1, mk(14'(k), 0, 0));
    check("R9 q count 100", q_err_cnt, 100);
    check("R10 i clean", {i_err, i_err_cnt}, 0);
    for (int k = 101; k <= 65600; k++) step(1, 1, mk(14'(k), 0, 0));
    check("R9 q count saturates", q_err_cnt, 16'hffff);
    check("R9 q flag", q_err, 1);

    // R7: uninverted I lane (zero) would read as 0x3FFF and never lock
    step(0, 0, 0);
    step(1, 1, {16'h0000, 16'h0000});
    check("R7 I inversion", {i_locked, q_locked}, 2'b01);

    done = 1'b1;
    summary();
  end
endmodule